// File: doc/BRIEF.md
# Inter-Processor Dependence Tracker

This block sits next to a coherence directory and records which processors have passed data to one another since their last checkpoint. Every access that reaches the directory is presented as one request. The request carries the processor number, the line index and an operation code. For each tracked line the block remembers which processor wrote it last. For each processor it keeps bitmaps of its producers and its consumers, plus a Bloom-filter signature of the lines that processor has written.

A processor's state is cleared when it checkpoints or rolls back. The last-writer fields are never swept in bulk. Instead, a read checks the recorded writer's signature, and a miss shows that the writer ID is stale and must be dropped. Each processor owns two banks of bitmaps and signatures. When a checkpoint begins, the current bank becomes the draining bank while its dirty data is written back, and a fresh bank starts recording. A separate completion request retires the draining bank. Software reads the bitmaps to build checkpoint and rollback sets.

Top module: `dep_tracker`

## Requirements
- R1: After reset all bitmap outputs are zero, every line's last-writer entry is invalid, every current-bank pointer is 0 and no processor has a draining bank.
- R2: An accepted write (op 1) or exclusive read (op 2) makes the requester the line's valid last writer. The query port shows this from the cycle after acceptance.
- R3: A read (op 0 or 2) of a line whose valid last writer B differs from requester A, where the line hits in B's current-bank signature, sets bit B of A's current producer map and bit A of B's current consumer map on the next cycle. Processor p's map occupies bits [p*N +: N] of each map output.
- R4: A read of a line with no valid last writer, or whose last writer is the requester, changes no bitmap.
- R5: A read of a line whose valid last writer B is a different processor, where the line misses in both of B's signatures, records no dependence and invalidates the line's last writer.
- R6: Checkpoint begin (op 3) flips the requester's bank pointer and clears the new current bank's maps and signature. It marks the processor as draining and leaves every last-writer entry untouched.
- R7: If the line hits in the last writer B's draining-bank signature while B is draining, the read sets bit A in B's draining consumer map and bit B in A's current producer map. A hit in both of B's banks sets the consumer bit in both.
- R8: Checkpoint done (op 4) clears the requester's draining bank and ends draining. It has no effect when the processor is not draining.
- R9: Rollback (op 5) clears both of the requester's banks and its draining flag in one cycle and keeps its bank pointer.
- R10: A write inserts the line into its signature by setting bits h0 = line mod 256 and h1 = (37*line + 101) mod 256. A lookup hits when both bits are set, so lines never written can hit (a spurious dependence) and a written line always hits.
- R11: Op codes 6 and 7 have no effect, and nothing changes in a cycle without an accepted request.
- R12: The request ready output is high from the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted |
| reqOp | input | 3 | Operation code (0 read, 1 write, 2 exclusive read, 3 checkpoint begin, 4 checkpoint done, 5 rollback) |
| reqPid | input | PID_W | Requesting processor |
| reqLine | input | LINE_W | Directory line index |
| qLine | input | LINE_W | Line whose last writer is shown |
| qLwValid | output | 1 | Last-writer entry of qLine is valid |
| qLwId | output | PID_W | Last writer of qLine |
| prodCurMap | output | N*N | Current-bank producer maps of all processors |
| prodDrainMap | output | N*N | Draining-bank producer maps |
| consCurMap | output | N*N | Current-bank consumer maps |
| consDrainMap | output | N*N | Draining-bank consumer maps |
| curBank | output | N | Current-bank pointer per processor |
| drainBusy | output | N | Processor has a draining bank |

## Verification
The hardest state to reach is a stale last writer whose line still produces a signature hit. The stale ID alone is simple: a writer checkpoints twice, so the line leaves both of its banks while the directory entry stays. The false positive also needs other lines whose hash bits cover the stale line, written into the fresh bank. The bench searches the line space for such a cover and replays that sequence. Random traffic on a small pool of lines with frequent checkpoints then mixes hits in the draining bank, hits in the current bank and stale misses.

// File: rtl/dep_track_pkg.sv
package dep_track_pkg;

  typedef enum logic [2:0] {
    OP_READ        = 3'd0,
    OP_WRITE       = 3'd1,
    OP_READ_EXCL   = 3'd2,
    OP_CKPT_BEGIN  = 3'd3,
    OP_CKPT_DONE   = 3'd4,
    OP_ROLLBACK    = 3'd5
  } depOp_e;

  // strobes from control to datapath, one request per cycle
  typedef struct packed {
    logic setLw;
    logic clrLw;
    logic sigIns;
    logic depCur;
    logic depDrain;
    logic ckptBegin;
    logic ckptDone;
    logic rollback;
  } depStrobe_t;

endpackage

// File: rtl/dep_ctrl.sv
module dep_ctrl
  import dep_track_pkg::*;
#(
  parameter int NUM_PROC = 4,
  localparam int PID_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  input  logic [PID_W-1:0] reqPid,
  input  logic             lwValidRd,
  input  logic [PID_W-1:0] lwIdRd,
  input  logic             hitCur,
  input  logic             hitDrain,
  output logic             reqReady,
  output depStrobe_t       stb
);

  logic accept;
  logic otherWriter;

  always_ff @(posedge clk) begin
    if (rst) reqReady <= 1'b0;
    else     reqReady <= 1'b1;
  end

  assign accept      = reqValid && reqReady;
  assign otherWriter = lwValidRd && (lwIdRd != reqPid);

  always_comb begin
    stb = '0;
    if (accept) begin
      unique case (reqOp)
        OP_READ, OP_READ_EXCL: begin
          if (otherWriter) begin
            stb.depCur   = hitCur;
            stb.depDrain = hitDrain;
            stb.clrLw    = !hitCur && !hitDrain;
          end
          if (reqOp == OP_READ_EXCL) begin
            stb.setLw  = 1'b1;
            stb.sigIns = 1'b1;
          end
        end
        OP_WRITE: begin
          stb.setLw  = 1'b1;
          stb.sigIns = 1'b1;
        end
        OP_CKPT_BEGIN: stb.ckptBegin = 1'b1;
        OP_CKPT_DONE:  stb.ckptDone  = 1'b1;
        OP_ROLLBACK:   stb.rollback  = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dep_datapath.sv
module dep_datapath
  import dep_track_pkg::*;
#(
  parameter int NUM_PROC  = 4,
  parameter int NUM_LINES = 64,
  parameter int SIG_BITS  = 256,
  localparam int PID_W  = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int SIG_W  = $clog2(SIG_BITS),
  localparam int MAP_W  = NUM_PROC * NUM_PROC
) (
  input  logic                clk,
  input  logic                rst,
  input  depStrobe_t          stb,
  input  logic [PID_W-1:0]    reqPid,
  input  logic [LINE_W-1:0]   reqLine,
  input  logic [LINE_W-1:0]   qLine,
  output logic                lwValidRd,
  output logic [PID_W-1:0]    lwIdRd,
  output logic                hitCur,
  output logic                hitDrain,
  output logic                qLwValid,
  output logic [PID_W-1:0]    qLwId,
  output logic [MAP_W-1:0]    prodCurMap,
  output logic [MAP_W-1:0]    prodDrainMap,
  output logic [MAP_W-1:0]    consCurMap,
  output logic [MAP_W-1:0]    consDrainMap,
  output logic [NUM_PROC-1:0] curBank,
  output logic [NUM_PROC-1:0] drainBusy
);

  localparam logic [31:0] HASH_MUL = 32'd37;
  localparam logic [31:0] HASH_ADD = 32'd101;

  logic [NUM_LINES-1:0] lwValid;
  logic [PID_W-1:0]     lwId    [NUM_LINES];
  logic [NUM_PROC-1:0]  prodMap [NUM_PROC][2];
  logic [NUM_PROC-1:0]  consMap [NUM_PROC][2];
  logic [SIG_BITS-1:0]  wrSig   [NUM_PROC][2];

  function automatic logic [SIG_W-1:0] hashLo(input logic [LINE_W-1:0] ln);
    logic [31:0] t;
    t = 32'(ln);
    return t[SIG_W-1:0];
  endfunction

  function automatic logic [SIG_W-1:0] hashHi(input logic [LINE_W-1:0] ln);
    logic [31:0] t;
    t = 32'(ln) * HASH_MUL + HASH_ADD;
    return t[SIG_W-1:0];
  endfunction

  logic [SIG_W-1:0] reqHashLo, reqHashHi;
  logic             ownerBank;
  logic             reqBank;

  assign reqHashLo = hashLo(reqLine);
  assign reqHashHi = hashHi(reqLine);
  assign lwValidRd = lwValid[reqLine];
  assign lwIdRd    = lwId[reqLine];
  assign ownerBank = curBank[lwIdRd];
  assign reqBank   = curBank[reqPid];

  assign hitCur   = wrSig[lwIdRd][ownerBank][reqHashLo] &&
                    wrSig[lwIdRd][ownerBank][reqHashHi];
  assign hitDrain = drainBusy[lwIdRd] &&
                    wrSig[lwIdRd][!ownerBank][reqHashLo] &&
                    wrSig[lwIdRd][!ownerBank][reqHashHi];

  assign qLwValid = lwValid[qLine];
  assign qLwId    = lwId[qLine];

  always_ff @(posedge clk) begin
    if (rst) begin
      lwValid   <= '0;
      curBank   <= '0;
      drainBusy <= '0;
      for (int l = 0; l < NUM_LINES; l++) lwId[l] <= '0;
      for (int p = 0; p < NUM_PROC; p++) begin
        for (int b = 0; b < 2; b++) begin
          prodMap[p][b] <= '0;
          consMap[p][b] <= '0;
          wrSig[p][b]   <= '0;
        end
      end
    end else begin
      if (stb.setLw) begin
        lwValid[reqLine] <= 1'b1;
        lwId[reqLine]    <= reqPid;
      end else if (stb.clrLw) begin
        lwValid[reqLine] <= 1'b0;
      end
      if (stb.sigIns) begin
        wrSig[reqPid][reqBank][reqHashLo] <= 1'b1;
        wrSig[reqPid][reqBank][reqHashHi] <= 1'b1;
      end
      if (stb.depCur || stb.depDrain)
        prodMap[reqPid][reqBank][lwIdRd] <= 1'b1;
      if (stb.depCur)
        consMap[lwIdRd][ownerBank][reqPid] <= 1'b1;
      if (stb.depDrain)
        consMap[lwIdRd][!ownerBank][reqPid] <= 1'b1;
      if (stb.ckptBegin) begin
        curBank[reqPid]            <= !reqBank;
        drainBusy[reqPid]          <= 1'b1;
        prodMap[reqPid][!reqBank]  <= '0;
        consMap[reqPid][!reqBank]  <= '0;
        wrSig[reqPid][!reqBank]    <= '0;
      end
      if (stb.ckptDone && drainBusy[reqPid]) begin
        drainBusy[reqPid]          <= 1'b0;
        prodMap[reqPid][!reqBank]  <= '0;
        consMap[reqPid][!reqBank]  <= '0;
        wrSig[reqPid][!reqBank]    <= '0;
      end
      if (stb.rollback) begin
        drainBusy[reqPid] <= 1'b0;
        for (int b = 0; b < 2; b++) begin
          prodMap[reqPid][b] <= '0;
          consMap[reqPid][b] <= '0;
          wrSig[reqPid][b]   <= '0;
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_PROC; p++) begin : g_maps
    assign prodCurMap[p*NUM_PROC +: NUM_PROC]   = prodMap[p][curBank[p]];
    assign prodDrainMap[p*NUM_PROC +: NUM_PROC] = prodMap[p][!curBank[p]];
    assign consCurMap[p*NUM_PROC +: NUM_PROC]   = consMap[p][curBank[p]];
    assign consDrainMap[p*NUM_PROC +: NUM_PROC] = consMap[p][!curBank[p]];
  end

endmodule

// File: rtl/dep_tracker.sv
module dep_tracker
  import dep_track_pkg::*;
#(
  parameter int NUM_PROC  = 4,
  parameter int NUM_LINES = 64,
  parameter int SIG_BITS  = 256,
  localparam int PID_W  = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int MAP_W  = NUM_PROC * NUM_PROC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [2:0]          reqOp,
  input  logic [PID_W-1:0]    reqPid,
  input  logic [LINE_W-1:0]   reqLine,
  input  logic [LINE_W-1:0]   qLine,
  output logic                qLwValid,
  output logic [PID_W-1:0]    qLwId,
  output logic [MAP_W-1:0]    prodCurMap,
  output logic [MAP_W-1:0]    prodDrainMap,
  output logic [MAP_W-1:0]    consCurMap,
  output logic [MAP_W-1:0]    consDrainMap,
  output logic [NUM_PROC-1:0] curBank,
  output logic [NUM_PROC-1:0] drainBusy
);

  depStrobe_t       stb;
  logic             lwValidRd;
  logic [PID_W-1:0] lwIdRd;
  logic             hitCur;
  logic             hitDrain;

  dep_ctrl #(.NUM_PROC(NUM_PROC)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqPid    (reqPid),
    .lwValidRd (lwValidRd),
    .lwIdRd    (lwIdRd),
    .hitCur    (hitCur),
    .hitDrain  (hitDrain),
    .reqReady  (reqReady),
    .stb       (stb)
  );

  dep_datapath #(
    .NUM_PROC  (NUM_PROC),
    .NUM_LINES (NUM_LINES),
    .SIG_BITS  (SIG_BITS)
  ) i_datapath (
    .clk          (clk),
    .rst          (rst),
    .stb          (stb),
    .reqPid       (reqPid),
    .reqLine      (reqLine),
    .qLine        (qLine),
    .lwValidRd    (lwValidRd),
    .lwIdRd       (lwIdRd),
    .hitCur       (hitCur),
    .hitDrain     (hitDrain),
    .qLwValid     (qLwValid),
    .qLwId        (qLwId),
    .prodCurMap   (prodCurMap),
    .prodDrainMap (prodDrainMap),
    .consCurMap   (consCurMap),
    .consDrainMap (consDrainMap),
    .curBank      (curBank),
    .drainBusy    (drainBusy)
  );

endmodule

// File: rtl/dep_tracker_chk.sv
module dep_tracker_chk #(
  parameter int NUM_PROC  = 4,
  parameter int NUM_LINES = 64,
  localparam int PID_W  = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int MAP_W  = NUM_PROC * NUM_PROC
) (
  input logic                clk,
  input logic                rst,
  input logic                reqValid,
  input logic                reqReady,
  input logic [2:0]          reqOp,
  input logic [PID_W-1:0]    reqPid,
  input logic [MAP_W-1:0]    prodCurMap,
  input logic [MAP_W-1:0]    prodDrainMap,
  input logic [MAP_W-1:0]    consCurMap,
  input logic [MAP_W-1:0]    consDrainMap,
  input logic [NUM_PROC-1:0] curBank,
  input logic [NUM_PROC-1:0] drainBusy
);

  logic                pAcc;
  logic [2:0]          pOp;
  logic [PID_W-1:0]    pPid;
  logic [NUM_PROC-1:0] pBank;
  logic [NUM_PROC-1:0] pDrain;
  logic [MAP_W-1:0]    pProdCur;
  logic                accNow;

  assign accNow = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      pAcc     <= 1'b0;
      pOp      <= '0;
      pPid     <= '0;
      pBank    <= '0;
      pDrain   <= '0;
      pProdCur <= '0;
    end else begin
      pAcc     <= accNow;
      pOp      <= reqOp;
      pPid     <= reqPid;
      pBank    <= curBank;
      pDrain   <= drainBusy;
      pProdCur <= prodCurMap;
    end
  end

  // R12: ready stays high once out of reset
  a_r12_ready_high: assert property (@(posedge clk) disable iff (rst)
    pAcc || !pAcc |=> reqReady);

  // R11: nothing moves without an accepted request
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !accNow |=> $stable({prodCurMap, prodDrainMap, consCurMap, consDrainMap,
                         curBank, drainBusy}));

  // R6: checkpoint begin flips the bank and starts fresh maps
  a_r6_begin_flip: assert property (@(posedge clk) disable iff (rst)
    pAcc && pOp == 3'd3 |->
      curBank[pPid] != pBank[pPid] && drainBusy[pPid] &&
      prodCurMap[pPid*NUM_PROC +: NUM_PROC] == '0 &&
      consCurMap[pPid*NUM_PROC +: NUM_PROC] == '0);

  // R9: rollback empties both banks and keeps the pointer
  a_r9_rollback_clear: assert property (@(posedge clk) disable iff (rst)
    pAcc && pOp == 3'd5 |->
      !drainBusy[pPid] && curBank[pPid] == pBank[pPid] &&
      prodCurMap[pPid*NUM_PROC +: NUM_PROC] == '0 &&
      prodDrainMap[pPid*NUM_PROC +: NUM_PROC] == '0 &&
      consCurMap[pPid*NUM_PROC +: NUM_PROC] == '0 &&
      consDrainMap[pPid*NUM_PROC +: NUM_PROC] == '0);

  // R3: data accesses only ever add producer bits
  a_r3_prod_grows: assert property (@(posedge clk) disable iff (rst)
    pAcc && pOp <= 3'd2 |-> (pProdCur & ~prodCurMap) == '0);

  // R8: checkpoint done on an idle processor changes nothing of it
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    pAcc && pOp == 3'd4 && !pDrain[pPid] |->
      !drainBusy[pPid] && curBank[pPid] == pBank[pPid]);

endmodule

bind dep_tracker dep_tracker_chk #(
  .NUM_PROC  (NUM_PROC),
  .NUM_LINES (NUM_LINES)
) i_dep_tracker_chk (
  .clk          (clk),
  .rst          (rst),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqOp        (reqOp),
  .reqPid       (reqPid),
  .prodCurMap   (prodCurMap),
  .prodDrainMap (prodDrainMap),
  .consCurMap   (consCurMap),
  .consDrainMap (consDrainMap),
  .curBank      (curBank),
  .drainBusy    (drainBusy)
);

// File: tb/test_dep_tracker.sv
module test_dep_tracker;

  localparam int NP    = 4;
  localparam int NL    = 64;
  localparam int SB    = 256;
  localparam int PID_W = 2;
  localparam int LINE_W = 6;
  localparam int MAP_W = NP * NP;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [2:0]        reqOp = '0;
  logic [PID_W-1:0]  reqPid = '0;
  logic [LINE_W-1:0] reqLine = '0;
  logic [LINE_W-1:0] qLine = '0;
  logic              qLwValid;
  logic [PID_W-1:0]  qLwId;
  logic [MAP_W-1:0]  prodCurMap, prodDrainMap, consCurMap, consDrainMap;
  logic [NP-1:0]     curBank, drainBusy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = !clk;

  dep_tracker i_dep_tracker (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqPid(reqPid), .reqLine(reqLine), .qLine(qLine),
    .qLwValid(qLwValid), .qLwId(qLwId), .prodCurMap(prodCurMap),
    .prodDrainMap(prodDrainMap), .consCurMap(consCurMap),
    .consDrainMap(consDrainMap), .curBank(curBank), .drainBusy(drainBusy)
  );

  // reference state
  bit           mLwV [NL];
  int           mLwId[NL];
  bit [NP-1:0]  mProd[NP][2];
  bit [NP-1:0]  mCons[NP][2];
  bit [SB-1:0]  mSig [NP][2];
  bit           mCur [NP];
  bit           mDrn [NP];

  function automatic int hA(int ln); return ln % SB; endfunction
  function automatic int hB(int ln); return (37 * ln + 101) % SB; endfunction
  function automatic bit sHit(int p, int b, int ln);
    return mSig[p][b][hA(ln)] && mSig[p][b][hB(ln)];
  endfunction

  function automatic void mClr(int p, int b);
    mProd[p][b] = '0; mCons[p][b] = '0; mSig[p][b] = '0;
  endfunction

  function automatic void mReset();
    for (int l = 0; l < NL; l++) begin mLwV[l] = 0; mLwId[l] = 0; end
    for (int p = 0; p < NP; p++) begin
      mCur[p] = 0; mDrn[p] = 0; mClr(p, 0); mClr(p, 1);
    end
  endfunction

  function automatic void mApply(int op, int p, int ln);
    int  w;
    bit  hc, hd;
    if (op == 0 || op == 2) begin
      if (mLwV[ln] && mLwId[ln] != p) begin
        w  = mLwId[ln];
        hc = sHit(w, int'(mCur[w]), ln);
        hd = mDrn[w] && sHit(w, int'(!mCur[w]), ln);
        if (hc || hd) mProd[p][mCur[p]][w] = 1'b1;
        if (hc) mCons[w][mCur[w]][p] = 1'b1;
        if (hd) mCons[w][!mCur[w]][p] = 1'b1;
        if (!hc && !hd) mLwV[ln] = 0;
      end
    end
    if (op == 1 || op == 2) begin
      mLwV[ln] = 1; mLwId[ln] = p;
      mSig[p][mCur[p]][hA(ln)] = 1'b1;
      mSig[p][mCur[p]][hB(ln)] = 1'b1;
    end
    if (op == 3) begin
      mCur[p] = !mCur[p]; mDrn[p] = 1; mClr(p, int'(mCur[p]));
    end
    if (op == 4 && mDrn[p]) begin
      mDrn[p] = 0; mClr(p, int'(!mCur[p]));
    end
    if (op == 5) begin
      mDrn[p] = 0; mClr(p, 0); mClr(p, 1);
    end
  endfunction

  function automatic logic [79:0] mPack();
    logic [MAP_W-1:0] pc, pd, cc, cd;
    logic [NP-1:0] cb, db;
    for (int p = 0; p < NP; p++) begin
      pc[p*NP +: NP] = mProd[p][mCur[p]];
      pd[p*NP +: NP] = mProd[p][!mCur[p]];
      cc[p*NP +: NP] = mCons[p][mCur[p]];
      cd[p*NP +: NP] = mCons[p][!mCur[p]];
      cb[p] = mCur[p]; db[p] = mDrn[p];
    end
    return {pc, pd, cc, cd, cb, db};
  endfunction

  task automatic check(string req, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkState(string req);
    check(req, {prodCurMap, prodDrainMap, consCurMap, consDrainMap,
                curBank, drainBusy}, mPack());
  endtask

  task automatic checkLine(string req, int ln);
    qLine = LINE_W'(ln);
    #1;
    check(req, {78'(qLwId), qLwValid, 1'b0},
          {78'(mLwV[ln] ? mLwId[ln] : int'(qLwId)), mLwV[ln], 1'b0});
  endtask

  task automatic doOp(int op, int p, int ln, string req);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 3'(op); reqPid = PID_W'(p); reqLine = LINE_W'(ln);
    @(negedge clk);
    reqValid = 1'b0;
    mApply(op, p, ln);
    checkState(req);
    checkLine(req, ln);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int c, a, b;
    bit found;
    void'($urandom(32'h5eed));
    mReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checkState("R1");
    checkLine("R1", 5);
    // R12 ready
    check("R12", 80'(reqReady), 80'd1);

    // R2 / R3
    doOp(1, 0, 5, "R2");
    doOp(0, 1, 5, "R3");
    // R4: own read and read of untouched line
    doOp(0, 0, 5, "R4");
    doOp(0, 2, 9, "R4");
    // R6: checkpoint begin keeps last writer
    doOp(3, 0, 0, "R6");
    checkLine("R6", 5);
    // R7: read hits draining bank of P0
    doOp(0, 2, 5, "R7");
    // R8: done clears draining bank; done when idle ignored
    doOp(4, 0, 0, "R8");
    doOp(4, 3, 0, "R8");
    // R5: stale writer now misses both banks
    doOp(0, 3, 5, "R5");
    // R9: rollback of P1
    doOp(1, 1, 7, "R9");
    doOp(3, 1, 0, "R9");
    doOp(1, 1, 8, "R9");
    doOp(0, 2, 8, "R9");
    doOp(5, 1, 0, "R9");
    // R11: unused codes and idle cycles
    doOp(6, 2, 8, "R11");
    doOp(7, 3, 8, "R11");
    repeat (4) @(negedge clk);
    checkState("R11");

    // R10: search for a false-positive cover
    found = 0; c = 0; a = 1; b = 2;
    for (int ci = 0; ci < NL && !found; ci++)
      for (int ai = 0; ai < NL && !found; ai++)
        for (int bi = 0; bi < NL && !found; bi++)
          if (ai != ci && bi != ci &&
              (hA(ai) == hA(ci) || hB(ai) == hA(ci) || hA(bi) == hA(ci) || hB(bi) == hA(ci)) &&
              (hA(ai) == hB(ci) || hB(ai) == hB(ci) || hA(bi) == hB(ci) || hB(bi) == hB(ci))) begin
            found = 1; c = ci; a = ai; b = bi;
          end
    doOp(1, 2, c, "R10");
    doOp(3, 2, 0, "R10");
    doOp(3, 2, 0, "R10");
    doOp(1, 2, a, "R10");
    doOp(1, 2, b, "R10");
    doOp(0, 0, c, "R10");

    // random phase on a small line pool
    for (int i = 0; i < 1500; i++) begin
      int r, op;
      r = $urandom_range(0, 99);
      if (r < 40) op = 0;
      else if (r < 65) op = 1;
      else if (r < 78) op = 2;
      else if (r < 88) op = 3;
      else if (r < 95) op = 4;
      else if (r < 98) op = 5;
      else op = 6;
      doOp(op, $urandom_range(0, NP-1), $urandom_range(0, 11), "R10");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule